// File: doc/BRIEF.md
# Per-Line DMA Slot Budget Meter

This block paces a video processor's DMA engine by counting how many transfer units the engine may spend on each scan line. When a transfer is started it records the transfer kind and its total length in units. From then on, every line-start strobe hands out one line's worth of units and takes them off the outstanding length. The line's allowance is looked up from the transfer kind, the current display width (32-cell or 40-cell) and whether the line is active or in blanking.

A fill transfer does not run straight away. It sits armed, with the busy flag already raised, until the CPU writes the data port. Memory-to-VRAM transfers and copies run from the first line start after they are accepted.

The grant count stays on its output until the next line start, so the memory sequencer can spend it over the line. When the outstanding length is used up, busy drops and a single-cycle done pulse is issued. Address generation and the memory accesses themselves are outside this block.

Top module: `dma_slot_meter`

## Requirements
- R1: While idle, a start request with a nonzero length latches the kind code and the length. Kind codes 0 and 1 (memory-to-VRAM) and 3 (copy) raise busy after that edge and begin metering at the next line start.
- R2: Kind code 2 (fill) raises busy after the start edge but grants nothing until a data-port write has been seen. The write moves the fill to running, and metering begins at the following line start.
- R3: A memory-to-VRAM transfer (codes 0 and 1) is allowed 16 units on an active line and 166 on a blanked line in 32-cell width. In 40-cell width it is allowed 18 and 204.
- R4: A fill is allowed 15 units on an active line and 165 on a blanked line in 32-cell width. In 40-cell width it is allowed 17 and 203.
- R5: A copy is allowed 8 units on an active line and 83 on a blanked line in 32-cell width. In 40-cell width it is allowed 9 and 102.
- R6: At each line start while running, the grant output takes the smaller of that line's allowance and the outstanding length, and holds it until the next line start. A line start while idle or armed sets the grant to 0. The width and blanking inputs are sampled in the line-start cycle.
- R7: The outstanding length drops by exactly the units granted. On the edge where it reaches zero, busy clears and done is high for that one cycle only.
- R8: A start request while busy is ignored, and so is a start request with zero length. The kind input has no effect after the start edge.
- R9: When a line start and a data-port write fall in the same cycle on an armed fill, that line's grant is 0. The first nonzero grant comes at the next line start.
- R10: After reset, busy, grant and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a transfer (taken only while idle) |
| dmaType | input | 2 | Transfer kind: 0/1 memory-to-VRAM, 2 fill, 3 copy |
| length | input | LEN_W | Total transfer length in units |
| wide | input | 1 | 1 = 40-cell width, 0 = 32-cell width |
| blank | input | 1 | 1 = the starting line is blanked |
| lineStart | input | 1 | One-cycle strobe at the start of each scan line |
| dataWrite | input | 1 | Data-port write strobe (starts an armed fill) |
| busy | output | 1 | Transfer armed or in progress |
| grant | output | 8 | Units granted for the current line |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
A data-port write and a line start can land in the same cycle while a fill is armed. The bench forces this coincidence in a directed step and also produces it at random. It expects a zero grant for that line and the fill's first allowance at the following line start.

A start request arriving in the same cycle as a line start, and start attempts during an active transfer, are also mixed into the random traffic. Every cycle is judged against a bench reference model of the metering rules.

// File: rtl/dma_slot_meter_pkg.sv
package dma_slot_meter_pkg;

  localparam int GRANT_W = 8;

  typedef enum logic [1:0] {
    KIND_MEM_A = 2'd0,
    KIND_MEM_B = 2'd1,
    KIND_FILL  = 2'd2,
    KIND_COPY  = 2'd3
  } dmaKind_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;      // capture length and kind
    logic grantNow;  // line start while running
    logic zeroGrant; // line start while not running
  } meterStrobe_t;

  // Allowance per line: index {active/blank}{32/40}
  localparam logic [GRANT_W-1:0] MEM_ACT_N  = 8'd16;
  localparam logic [GRANT_W-1:0] MEM_ACT_W  = 8'd18;
  localparam logic [GRANT_W-1:0] MEM_BLK_N  = 8'd166;
  localparam logic [GRANT_W-1:0] MEM_BLK_W  = 8'd204;
  localparam logic [GRANT_W-1:0] FILL_ACT_N = 8'd15;
  localparam logic [GRANT_W-1:0] FILL_ACT_W = 8'd17;
  localparam logic [GRANT_W-1:0] FILL_BLK_N = 8'd165;
  localparam logic [GRANT_W-1:0] FILL_BLK_W = 8'd203;
  localparam logic [GRANT_W-1:0] COPY_ACT_N = 8'd8;
  localparam logic [GRANT_W-1:0] COPY_ACT_W = 8'd9;
  localparam logic [GRANT_W-1:0] COPY_BLK_N = 8'd83;
  localparam logic [GRANT_W-1:0] COPY_BLK_W = 8'd102;

  function automatic logic [GRANT_W-1:0] slotBudget(dmaKind_e kind, logic wide, logic blank);
    logic [GRANT_W-1:0] val;
    unique case (kind)
      KIND_FILL: val = blank ? (wide ? FILL_BLK_W : FILL_BLK_N) : (wide ? FILL_ACT_W : FILL_ACT_N);
      KIND_COPY: val = blank ? (wide ? COPY_BLK_W : COPY_BLK_N) : (wide ? COPY_ACT_W : COPY_ACT_N);
      default:   val = blank ? (wide ? MEM_BLK_W  : MEM_BLK_N)  : (wide ? MEM_ACT_W  : MEM_ACT_N);
    endcase
    return val;
  endfunction

endpackage

// File: rtl/dma_slot_meter_ctrl.sv
module dma_slot_meter_ctrl
  import dma_slot_meter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startReq,
  input  logic [1:0]   dmaType,
  input  logic         lenZero,
  input  logic         lineStart,
  input  logic         dataWrite,
  input  logic         lastLine,
  output meterStrobe_t strobes,
  output logic         busy,
  output logic         done
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} meterState_e;

  meterState_e state, stateNext;
  logic        doneNext;

  always_comb begin
    stateNext         = state;
    doneNext          = 1'b0;
    strobes.load      = 1'b0;
    strobes.grantNow  = 1'b0;
    strobes.zeroGrant = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobes.zeroGrant = lineStart;
        if (startReq && !lenZero) begin
          strobes.load = 1'b1;
          stateNext    = (dmaType == KIND_FILL) ? ST_ARMED : ST_RUN;
        end
      end
      ST_ARMED: begin
        strobes.zeroGrant = lineStart;
        if (dataWrite) stateNext = ST_RUN;
      end
      ST_RUN: begin
        strobes.grantNow = lineStart;
        if (lineStart && lastLine) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dma_slot_meter_dp.sv
module dma_slot_meter_dp
  import dma_slot_meter_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  meterStrobe_t       strobes,
  input  logic [LEN_W-1:0]   length,
  input  logic [1:0]         dmaType,
  input  logic               wide,
  input  logic               blank,
  output logic [GRANT_W-1:0] grant,
  output logic               lastLine
);

  logic [LEN_W-1:0]   remaining;
  dmaKind_e           kindQ;
  logic [GRANT_W-1:0] budget;
  logic [LEN_W-1:0]   budgetExt;
  logic [GRANT_W-1:0] grantNext;

  assign budget    = slotBudget(kindQ, wide, blank);
  assign budgetExt = LEN_W'(budget);
  assign lastLine  = (remaining <= budgetExt);
  assign grantNext = lastLine ? remaining[GRANT_W-1:0] : budget;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      kindQ     <= KIND_MEM_A;
      grant     <= '0;
    end else begin
      if (strobes.load) begin
        remaining <= length;
        kindQ     <= dmaKind_e'(dmaType);
      end else if (strobes.grantNow) begin
        remaining <= remaining - LEN_W'(grantNext);
      end
      if (strobes.grantNow)       grant <= grantNext;
      else if (strobes.zeroGrant) grant <= '0;
    end
  end

endmodule

// File: rtl/dma_slot_meter.sv
module dma_slot_meter
  import dma_slot_meter_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [1:0]       dmaType,
  input  logic [LEN_W-1:0] length,
  input  logic             wide,
  input  logic             blank,
  input  logic             lineStart,
  input  logic             dataWrite,
  output logic             busy,
  output logic [7:0]       grant,
  output logic             done
);

  meterStrobe_t strobes;
  logic         lastLine;
  logic         lenZero;

  assign lenZero = (length == '0);

  dma_slot_meter_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .dmaType   (dmaType),
    .lenZero   (lenZero),
    .lineStart (lineStart),
    .dataWrite (dataWrite),
    .lastLine  (lastLine),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done)
  );

  dma_slot_meter_dp #(.LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .length   (length),
    .dmaType  (dmaType),
    .wide     (wide),
    .blank    (blank),
    .grant    (grant),
    .lastLine (lastLine)
  );

endmodule

// File: rtl/dma_slot_meter_chk.sv
module dma_slot_meter_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startReq,
  input logic [1:0]       dmaType,
  input logic [LEN_W-1:0] length,
  input logic             wide,
  input logic             blank,
  input logic             lineStart,
  input logic             dataWrite,
  input logic             busy,
  input logic [7:0]       grant,
  input logic             done
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !lineStart |=> $stable(grant));

  // R6
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (lineStart && !busy) |=> (grant == 8'd0));

  // R2
  fill_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && dmaType == 2'd2 && length != '0) |=> (busy && !done));

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && length == '0) |=> !busy);

  // R3
  grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) grant <= 8'd204);

endmodule

bind dma_slot_meter dma_slot_meter_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/dma_slot_meter_test.sv
module dma_slot_meter_test;

  localparam int PERIOD = 10;
  localparam int LEN_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             startReq;
  logic [1:0]       dmaType;
  logic [LEN_W-1:0] length;
  logic             wide;
  logic             blank;
  logic             lineStart;
  logic             dataWrite;
  logic             busy;
  logic [7:0]       grant;
  logic             done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 armed, 2 running
  int mState = 0;
  int mRem   = 0;
  int mType  = 0;
  int mGrant = 0;
  int mDone  = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_slot_meter #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .dmaType(dmaType), .length(length),
    .wide(wide), .blank(blank), .lineStart(lineStart), .dataWrite(dataWrite),
    .busy(busy), .grant(grant), .done(done)
  );

  function automatic int allowance(int ty, bit wd, bit bl);
    if (ty == 2) return bl ? (wd ? 203 : 165) : (wd ? 17 : 15);
    if (ty == 3) return bl ? (wd ? 102 : 83) : (wd ? 9 : 8);
    return bl ? (wd ? 204 : 166) : (wd ? 18 : 16);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, int'(busy), (mState != 0) ? 1 : 0, "busy");
    check(tag, int'(grant), mGrant, "grant");
    check(tag, int'(done), mDone, "done");
  endtask

  task automatic step(input bit st, input int ty, input int len, input bit ls,
                      input bit dw, input bit bl, input bit wd, input string tag);
    int g;
    startReq  = st;
    dmaType   = 2'(ty);
    length    = LEN_W'(len);
    lineStart = ls;
    dataWrite = dw;
    blank     = bl;
    wide      = wd;
    @(posedge clk);
    mDone = 0;
    case (mState)
      0: begin
        if (ls) mGrant = 0;
        if (st && len != 0) begin
          mRem = len; mType = ty; mState = (ty == 2) ? 1 : 2;
        end
      end
      1: begin
        if (ls) mGrant = 0;
        if (dw) mState = 2;
      end
      default: begin
        if (ls) begin
          g = allowance(mType, wd, bl);
          if (mRem < g) g = mRem;
          mGrant = g;
          mRem -= g;
          if (mRem == 0) begin mState = 0; mDone = 1; end
        end
      end
    endcase
    #1;
    compareAll(tag);
    startReq = 0; lineStart = 0; dataWrite = 0;
  endtask

  task automatic runOut(input bit bl, input bit wd, input string tag);
    for (int i = 0; i < 3000 && mState != 0; i++) step(0, 0, 0, 1, 0, bl, wd, tag);
    step(0, 0, 0, 0, 0, bl, wd, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ty, len;
    bit bl, wd;
    void'($urandom(32'd4242));
    rst_n = 0; startReq = 0; dmaType = 0; length = 0; wide = 0; blank = 0;
    lineStart = 0; dataWrite = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10", int'(busy), 0, "busy");
    check("R10", int'(grant), 0, "grant");
    check("R10", int'(done), 0, "done");
    rst_n = 1;

    // R1 R3: memory 32-cell active, 40 units -> 16,16,8 then done (R7)
    step(1, 0, 40, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");

    // R3: memory 40-cell blank, 500 -> 204,204,92
    step(1, 1, 500, 0, 0, 1, 1, "R1");
    runOut(1, 1, "R3");
    // R3: 32-cell blank 166, 40-cell active 18
    step(1, 0, 200, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 1, 0, "R3");
    step(0, 0, 0, 1, 0, 0, 1, "R3");
    runOut(0, 0, "R3");

    // R2 R9 R4: fill arms, coincident write + line start grants 0
    step(1, 2, 600, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 1, 0, "R9");
    step(0, 0, 0, 1, 0, 1, 0, "R4");
    step(0, 0, 0, 1, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, 1, "R4");
    step(0, 0, 0, 1, 0, 0, 0, "R4");
    runOut(1, 1, "R4");

    // R5: copy 40-cell blank 102, 32-cell blank 83, actives 8/9
    step(1, 3, 250, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 1, 1, "R5");
    step(0, 0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 1, "R5");
    runOut(1, 1, "R5");

    // R8: zero length, start while busy, kind change mid-transfer
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 3, 30, 0, 0, 0, 0, "R8");
    step(1, 0, 900, 0, 0, 0, 0, "R8");
    step(0, 2, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 1, 0, 0, "R8");
    runOut(0, 0, "R8");
    // R6: line start while idle keeps grant zero
    step(0, 0, 0, 1, 0, 1, 1, "R6");

    // random traffic
    for (int n = 0; n < 20000; n++) begin
      ty  = int'($urandom_range(0, 3));
      len = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 700));
      bl  = ($urandom_range(0, 2) == 0);
      wd  = $urandom_range(0, 1) == 1;
      step(($urandom_range(0, 5) == 0), ty, len, ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 6) == 0), bl, wd, "R6");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule